// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block observes the clock and data lines of a two-wire open-drain serial bus and reports the framing conditions on it. It brings both raw line levels into the local clock domain, then detects the edges that mark the opening and closing of a transfer. The opening condition is a high-to-low data transition while the clock line is high. The closing condition is a low-to-high data transition while the clock line is high.

The monitor keeps a bus-occupied level for any local master that must wait before it takes the bus. It tells an opening condition on a free bus apart from one on an already occupied bus, which is a restart. It also counts clock pulses after each opening condition. A transfer that is closed before any complete clock pulse is flagged as an illegal empty message. All condition outputs are single-cycle pulses.

Top module: `bus_cond_monitor`

## Requirements
- R1: While rst_ni is low, busy_o is 0 and start_o, rstart_o, stop_o and empty_o are all 0; the internal line history resets to idle-high.
- R2: A data fall while the clock line is high, seen on a free bus, pulses start_o for exactly one cycle and sets busy_o. Both outputs change on the third rising clock edge after the input change (two synchronizer flops plus one output register).
- R3: A data rise while the clock line is high pulses stop_o for one cycle and clears busy_o.
- R4: An opening condition seen while busy_o is 1 pulses rstart_o instead of start_o, and busy_o stays 1.
- R5: At a closing condition on an occupied bus, empty_o pulses together with stop_o when fewer than two clock-line rising edges were seen since the last opening or restart. The rise that precedes the closing condition is one of these, so at least one complete clock pulse must lie between.
- R6: Data transitions while the clock line is low, and clock-line toggles, produce no condition pulse.
- R7: A closing condition on a free bus pulses stop_o but not empty_o, and busy_o stays 0.
- R8: A data edge sampled in the same cycle as a clock-line edge is not a condition: the clock line must be high in both the current and previous synchronized samples.
- R9: The clock-pulse counter saturates at its maximum and does not wrap. With CNT_W=4, a transfer with 15 data bits ends without empty_o.
- R10: A restart clears the clock-pulse count, so a restart followed directly by a closing condition raises empty_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw clock line level |
| sda_i | input | 1 | Raw data line level |
| start_o | output | 1 | One-cycle pulse on an opening condition on a free bus |
| rstart_o | output | 1 | One-cycle pulse on an opening condition on an occupied bus |
| stop_o | output | 1 | One-cycle pulse on a closing condition |
| empty_o | output | 1 | One-cycle pulse, with stop_o, for a transfer with no complete clock pulse |
| busy_o | output | 1 | Bus occupied, from an opening condition until a closing condition |

## Verification
A corrupted busy flag appears at the very next opening condition: it is reported as a restart instead of an opening, or the other way round. It also appears at the next closing condition, which then raises or omits empty_o wrongly. A stale or wrapped pulse counter shows only at the next closing condition, as a missing or extra empty_o pulse. A wrong line history shows within three clock cycles of the offending line change, as a spurious or missing condition pulse.

// File: rtl/bus_cond_pkg.sv
package bus_cond_pkg;
  // line events decoded from synchronized samples
  typedef struct packed {
    logic open_c;   // data fell, clock held high
    logic close_c;  // data rose, clock held high
    logic clk_rise; // clock line rose
  } line_evt_t;
endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '1;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '1;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bcm_edge.sv
module bcm_edge
  import bus_cond_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      scl_s_i,
  input  logic      sda_s_i,
  output line_evt_t evt_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end

  logic scl_held_hi;
  assign scl_held_hi = scl_s_i & scl_prev_q;

  always_comb begin
    evt_o.open_c   = scl_held_hi & sda_prev_q & ~sda_s_i;
    evt_o.close_c  = scl_held_hi & ~sda_prev_q & sda_s_i;
    evt_o.clk_rise = scl_s_i & ~scl_prev_q;
  end
endmodule

// File: rtl/bcm_tracker.sv
module bcm_tracker
  import bus_cond_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_evt_t evt_i,
  output logic      start_o,
  output logic      rstart_o,
  output logic      stop_o,
  output logic      empty_o,
  output logic      busy_o
);
  localparam logic [CNT_W-1:0] CntMax  = '1;
  localparam logic [CNT_W-1:0] MinEdge = CNT_W'(2);

  logic             busy_q;
  logic [CNT_W-1:0] rise_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      rise_cnt_q <= '0;
      start_o    <= 1'b0;
      rstart_o   <= 1'b0;
      stop_o     <= 1'b0;
      empty_o    <= 1'b0;
    end else begin
      start_o  <= 1'b0;
      rstart_o <= 1'b0;
      stop_o   <= 1'b0;
      empty_o  <= 1'b0;
      if (evt_i.open_c) begin
        start_o    <= ~busy_q;
        rstart_o   <= busy_q;
        busy_q     <= 1'b1;
        rise_cnt_q <= '0;
      end else if (evt_i.close_c) begin
        stop_o     <= 1'b1;
        empty_o    <= busy_q && (rise_cnt_q < MinEdge);
        busy_q     <= 1'b0;
        rise_cnt_q <= '0;
      end else if (evt_i.clk_rise && busy_q && rise_cnt_q != CntMax) begin
        rise_cnt_q <= rise_cnt_q + 1'b1;  // saturating
      end
    end

  assign busy_o = busy_q;
endmodule

// File: rtl/bus_cond_monitor.sv
module bus_cond_monitor
  import bus_cond_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic rstart_o,
  output logic stop_o,
  output logic empty_o,
  output logic busy_o
);
  logic [1:0] lines_s;
  line_evt_t  evt;

  bcm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  bcm_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_s_i(lines_s[1]),
    .sda_s_i(lines_s[0]),
    .evt_o  (evt)
  );

  bcm_tracker #(.CNT_W(CNT_W)) i_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .start_o (start_o),
    .rstart_o(rstart_o),
    .stop_o  (stop_o),
    .empty_o (empty_o),
    .busy_o  (busy_o)
  );
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic start_o,
  input logic rstart_o,
  input logic stop_o,
  input logic empty_o,
  input logic busy_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !start_o && !rstart_o && !stop_o && !empty_o);

  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o && !$past(busy_o));

  a_r2_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r2_busy_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> start_o);

  a_r3_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !busy_o);

  a_r3_busy_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> stop_o);

  a_r4_rstart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstart_o |-> busy_o && $past(busy_o));

  a_r5_empty_with_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> stop_o && $past(busy_o));

  a_r6_events_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, rstart_o, stop_o}));
endmodule

bind bus_cond_monitor bcm_checker i_chk (.*);

// File: tb/test_bus_cond_monitor.sv
module test_bus_cond_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic start_p, rstart_p, stop_p, empty_p, busy;

  int n_chk = 0, n_bad = 0;
  int c_start = 0, c_rstart = 0, c_stop = 0, c_empty = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_cond_monitor i_bus_cond_monitor (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .start_o(start_p), .rstart_o(rstart_p), .stop_o(stop_p),
    .empty_o(empty_p), .busy_o(busy)
  );

  always @(negedge clk) begin
    c_start  <= c_start  + int'(start_p);
    c_rstart <= c_rstart + int'(rstart_p);
    c_stop   <= c_stop   + int'(stop_p);
    c_empty  <= c_empty  + int'(empty_p);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line(input logic c, input logic d);
    @(negedge clk); scl = c; sda = d; wcyc(3);
  endtask

  task automatic do_open();   line(1, 1); line(1, 0); line(0, 0); endtask
  task automatic do_close();  line(0, 0); line(1, 0); line(1, 1); endtask
  task automatic do_ropen();  line(0, 1); line(1, 1); line(1, 0); line(0, 0); endtask
  task automatic do_bit(input logic b); line(0, b); line(1, b); line(0, b); endtask

  // expect counter deltas over a scenario
  task automatic expect_delta(input string tag, input int s0, input int r0, input int p0,
                              input int e0, input int ds, input int dr, input int dp, input int de);
    wcyc(5);
    check(c_start - s0 == ds,   {tag, " start"},  c_start - s0,  ds);
    check(c_rstart - r0 == dr,  {tag, " rstart"}, c_rstart - r0, dr);
    check(c_stop - p0 == dp,    {tag, " stop"},   c_stop - p0,   dp);
    check(c_empty - e0 == de,   {tag, " empty"},  c_empty - e0,  de);
  endtask

  task automatic t_reset();
    wcyc(4);
    check(busy == 0, "R1 busy", busy, 0);
    check({start_p, rstart_p, stop_p, empty_p} == 0, "R1 pulses",
          {start_p, rstart_p, stop_p, empty_p}, 0);
    rst_n = 1'b1; wcyc(4);
  endtask

  task automatic t_open_latency();
    int s0 = c_start;
    @(negedge clk); sda = 1'b0;
    wcyc(2);
    check(start_p == 0, "R2 early", start_p, 0);
    wcyc(1);
    check(start_p == 1, "R2 pulse", start_p, 1);
    check(busy == 1, "R2 busy", busy, 1);
    check(rstart_p == 0, "R2 not restart", rstart_p, 0);
    wcyc(1);
    check(start_p == 0, "R2 width", start_p, 0);
    check(c_start - s0 == 1, "R2 count", c_start - s0, 1);
    line(0, 0);
  endtask

  task automatic t_bits_close();
    int s0 = c_start, r0 = c_rstart, p0 = c_stop, e0 = c_empty;
    for (int i = 0; i < 8; i++) do_bit(logic'((8'hA6 >> (7 - i)) & 1));
    check(busy == 1, "R6 busy during data", busy, 1);
    check(c_stop == p0 && c_start == s0, "R6 no events on data", c_stop - p0, 0);
    do_close();
    expect_delta("R3", s0, r0, p0, e0, 0, 0, 1, 0);
    check(busy == 0, "R3 busy cleared", busy, 0);
  endtask

  task automatic t_empty_msgs();
    int s0 = c_start, r0 = c_rstart, p0 = c_stop, e0 = c_empty;
    do_open(); do_close();
    expect_delta("R5 clock-low empty", s0, r0, p0, e0, 1, 0, 1, 1);
    s0 = c_start; p0 = c_stop; e0 = c_empty;
    line(1, 1); line(1, 0); line(1, 1);
    expect_delta("R5 direct empty", s0, r0, p0, e0, 1, 0, 1, 1);
    check(busy == 0, "R5 busy", busy, 0);
  endtask

  task automatic t_restart();
    int s0 = c_start, r0 = c_rstart, p0 = c_stop, e0 = c_empty;
    do_open();
    for (int i = 0; i < 3; i++) do_bit(1'b0);
    do_ropen();
    check(busy == 1, "R4 busy held", busy, 1);
    check(c_rstart - r0 == 1, "R4 restart", c_rstart - r0, 1);
    check(c_start - s0 == 1, "R4 no second start", c_start - s0, 1);
    do_close();
    expect_delta("R10", s0, r0, p0, e0, 1, 1, 1, 1);
  endtask

  task automatic t_idle_close();
    int s0 = c_start, r0 = c_rstart, p0 = c_stop, e0 = c_empty;
    line(0, 1); line(0, 0); line(1, 0); line(1, 1);
    expect_delta("R7", s0, r0, p0, e0, 0, 0, 1, 0);
    check(busy == 0, "R7 busy", busy, 0);
  endtask

  task automatic t_coincident();
    int s0 = c_start, r0 = c_rstart, p0 = c_stop, e0 = c_empty;
    line(1, 1); line(0, 0); line(1, 1);
    expect_delta("R8", s0, r0, p0, e0, 0, 0, 0, 0);
    check(busy == 0, "R8 busy", busy, 0);
  endtask

  task automatic t_saturate();
    int s0 = c_start, r0 = c_rstart, p0 = c_stop, e0 = c_empty;
    do_open();
    for (int i = 0; i < 15; i++) do_bit(logic'(i & 1));
    do_close();
    expect_delta("R9", s0, r0, p0, e0, 1, 0, 1, 0);
  endtask

  initial begin
    t_reset();
    t_open_latency();
    t_bits_close();
    t_empty_msgs();
    t_restart();
    t_idle_close();
    t_coincident();
    t_saturate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule